// File: doc/BRIEF.md
# Software Write Protect Sequencer

This block sits in front of the page buffer of a byte-wide non-volatile memory. It watches each write strobe, with its 13-bit address and 8-bit data, and picks out fixed multi-step command keys. All keys open with the same steps. The data value of a later step decides which command the key is: lock the array, unlock it, clear the whole array, stop the automatic pre-clear, or restore the automatic pre-clear. Writes that belong to a key are never handed to the page. Every other write gets a one-cycle permit that tells the page controller whether to load that byte.

A page cycle runs from one `cycle_close` pulse to the next. The page controller raises `cycle_close` when its byte-load window ends. Lock and unlock take effect only at that close, and only if at least one permitted data byte followed the key in the same cycle. A key is recognised only at the start of a cycle, before the first data byte. If no strobe arrives for `GAP_LIMIT` consecutive clocks, a key that is partly entered is abandoned.

The lock state survives the ordinary reset. Only `factory_init` clears it. The reset does clear the pre-clear-off flag, in the same way a power loss restores automatic pre-clear.

Top module: `wp_keyseq`

## Requirements
- R1: Lock key. The key is address 0x1555 with data 0xAA, then 0x0AAA with 0x55, then 0x1555 with 0xA0. If at least one permitted data write follows it in the same cycle, `prot_on` reads 1 in the cycle after `cycle_close`. A lock key with no data write after it leaves `prot_on` unchanged.
- R2: While `prot_on` is 1, a data write raises `commit_ok` in the cycle after its strobe only if a lock or unlock key completed earlier in the same page cycle. Otherwise `commit_ok` stays 0. While `prot_on` is 0, every data write raises `commit_ok`.
- R3: Unlock key. The six-step key is 0x1555/0xAA, 0x0AAA/0x55, 0x1555/0x80, 0x1555/0xAA, 0x0AAA/0x55, 0x1555/0x20. When it is followed by a data write and then `cycle_close`, `prot_on` becomes 0, and later data writes need no key.
- R4: The six-step key ending in 0x1555/0x10 raises `clear_pulse` for exactly one cycle, the cycle after the final strobe.
- R5: The six-step key ending in 0x1555/0x40 sets `autoclr_off`. The key ending in 0x1555/0x50 clears it. Both changes appear in the cycle after the final strobe and take effect even with no data write.
- R6: A write that matches the next key step never raises `commit_ok`. A write that does not match sends the sequence back to its start, and that write is handled as a data write.
- R7: A partly entered key survives up to `GAP_LIMIT`-1 idle clocks between strobes. After `GAP_LIMIT` idle clocks it is abandoned.
- R8: `cycle_close` abandons any partly entered key. It also ends the permit that a completed key granted.
- R9: `rst` clears `autoclr_off`, `clear_pulse`, `commit_ok` and the key state, and leaves `prot_on` unchanged. `factory_init` clears `prot_on`.
- R10: After the first data write of a page cycle, or after a lock or unlock key completes, no key is recognised until the next `cycle_close`. Key-shaped writes in that span are data writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; does not touch the lock state |
| factory_init | input | 1 | Synchronous clear of the lock state |
| wr_stb | input | 1 | One-cycle write strobe toward the page buffer |
| wr_addr | input | 13 | Write address |
| wr_data | input | 8 | Write data |
| cycle_close | input | 1 | Pulse marking the end of the current page-load cycle |
| prot_on | output | 1 | Lock state: 1 means writes need a key |
| autoclr_off | output | 1 | 1 means automatic pre-clear before programming is disabled |
| clear_pulse | output | 1 | One-cycle request to clear the whole array |
| commit_ok | output | 1 | Pulses in the cycle after a data strobe that may be loaded into the page |

## Verification
The assertions take for granted that `wr_stb` and `cycle_close` are never high in the same cycle. They also assume that `factory_init` is pulsed, together with or before the first release of `rst`, so that the lock state starts out defined. The bench drives every write, idle stretch, close, reset and init through separate tasks, one clock at a time, so the two pulses can never overlap. Randomly chosen idle gaps sometimes run past `GAP_LIMIT`, which exercises the abandonment rule within those same bounds.

// File: rtl/wp_keyseq_pkg.sv
package wp_keyseq_pkg;

    localparam int ADDR_W = 13;
    localparam int DATA_W = 8;
    localparam int STEP_W = 3;

    localparam logic [ADDR_W-1:0] KEY_ADR_HI = 13'h1555;
    localparam logic [ADDR_W-1:0] KEY_ADR_LO = 13'h0AAA;

    localparam logic [DATA_W-1:0] KD_OPEN    = 8'hAA;
    localparam logic [DATA_W-1:0] KD_SECOND  = 8'h55;
    localparam logic [DATA_W-1:0] KD_LOCK    = 8'hA0;
    localparam logic [DATA_W-1:0] KD_EXTEND  = 8'h80;
    localparam logic [DATA_W-1:0] KD_UNLOCK  = 8'h20;
    localparam logic [DATA_W-1:0] KD_WIPE    = 8'h10;
    localparam logic [DATA_W-1:0] KD_ACOFF   = 8'h40;
    localparam logic [DATA_W-1:0] KD_ACON    = 8'h50;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_LOCK,
        CMD_UNLOCK,
        CMD_WIPE,
        CMD_AC_OFF,
        CMD_AC_ON
    } cmd_e;

    typedef struct packed {
        logic hit;
        cmd_e cmd;
    } step_res_t;

    // Evaluate one write against the key step that is expected next.
    function automatic step_res_t eval_step(input logic [STEP_W-1:0] step,
                                            input logic [ADDR_W-1:0] adr,
                                            input logic [DATA_W-1:0] dat);
        step_res_t r;
        r.hit = 1'b0;
        r.cmd = CMD_NONE;
        case (step)
            3'd0, 3'd3: r.hit = (adr == KEY_ADR_HI) && (dat == KD_OPEN);
            3'd1, 3'd4: r.hit = (adr == KEY_ADR_LO) && (dat == KD_SECOND);
            3'd2: begin
                if (adr == KEY_ADR_HI) begin
                    if (dat == KD_LOCK) begin
                        r.hit = 1'b1;
                        r.cmd = CMD_LOCK;
                    end else if (dat == KD_EXTEND) begin
                        r.hit = 1'b1;
                    end
                end
            end
            3'd5: begin
                if (adr == KEY_ADR_HI) begin
                    case (dat)
                        KD_UNLOCK: r.cmd = CMD_UNLOCK;
                        KD_WIPE:   r.cmd = CMD_WIPE;
                        KD_ACOFF:  r.cmd = CMD_AC_OFF;
                        KD_ACON:   r.cmd = CMD_AC_ON;
                        default:   r.cmd = CMD_NONE;
                    endcase
                    r.hit = (r.cmd != CMD_NONE);
                end
            end
            default: r.hit = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/wp_keyseq_match.sv
module wp_keyseq_match
    import wp_keyseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic [ADDR_W-1:0] adr,
    input  logic [DATA_W-1:0] dat,
    input  logic              live,
    input  logic              abort,
    output logic              key_hit,
    output cmd_e              key_cmd,
    output logic              busy
);
    logic [STEP_W-1:0] step_q;
    step_res_t         res;

    always_comb begin
        res     = eval_step(step_q, adr, dat);
        key_hit = stb && live && res.hit;
        key_cmd = key_hit ? res.cmd : CMD_NONE;
        busy    = (step_q != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= '0;
        end else if (stb) begin
            if (key_hit && (res.cmd == CMD_NONE))
                step_q <= step_q + STEP_W'(1);
            else
                step_q <= '0;
        end else if (abort) begin
            step_q <= '0;
        end
    end
endmodule

// File: rtl/wp_keyseq_gap.sv
module wp_keyseq_gap #(
    parameter int LIMIT = 50000
) (
    input  logic clk,
    input  logic rst,
    input  logic armed,
    input  logic kick,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    assign expire = armed && !kick && (cnt_q == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || kick || !armed || expire)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CW'(1);
    end
endmodule

// File: rtl/wp_keyseq_mode.sv
module wp_keyseq_mode
    import wp_keyseq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic factory_init,
    input  logic stb,
    input  logic key_hit,
    input  cmd_e key_cmd,
    input  logic cycle_close,
    output logic prot_on,
    output logic autoclr_off,
    output logic clear_pulse,
    output logic commit_ok,
    output logic live,
    output logic unlock_q
);
    logic pend_lock_q, pend_unlock_q, seen_q;
    logic may_load;

    assign may_load = !prot_on || unlock_q;

    // Lock state: deliberately outside the ordinary reset.
    always_ff @(posedge clk) begin
        if (factory_init)
            prot_on <= 1'b0;
        else if (cycle_close && seen_q) begin
            if (pend_lock_q)
                prot_on <= 1'b1;
            else if (pend_unlock_q)
                prot_on <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live          <= 1'b1;
            unlock_q      <= 1'b0;
            pend_lock_q   <= 1'b0;
            pend_unlock_q <= 1'b0;
            seen_q        <= 1'b0;
            autoclr_off   <= 1'b0;
            clear_pulse   <= 1'b0;
            commit_ok     <= 1'b0;
        end else begin
            clear_pulse <= 1'b0;
            commit_ok   <= 1'b0;
            if (cycle_close) begin
                live          <= 1'b1;
                unlock_q      <= 1'b0;
                pend_lock_q   <= 1'b0;
                pend_unlock_q <= 1'b0;
                seen_q        <= 1'b0;
            end else if (stb) begin
                if (key_hit) begin
                    case (key_cmd)
                        CMD_LOCK: begin
                            unlock_q      <= 1'b1;
                            pend_lock_q   <= 1'b1;
                            pend_unlock_q <= 1'b0;
                            live          <= 1'b0;
                        end
                        CMD_UNLOCK: begin
                            unlock_q      <= 1'b1;
                            pend_unlock_q <= 1'b1;
                            pend_lock_q   <= 1'b0;
                            live          <= 1'b0;
                        end
                        CMD_WIPE:   clear_pulse <= 1'b1;
                        CMD_AC_OFF: autoclr_off <= 1'b1;
                        CMD_AC_ON:  autoclr_off <= 1'b0;
                        default:    ;
                    endcase
                end else begin
                    live      <= 1'b0;
                    commit_ok <= may_load;
                    if (may_load)
                        seen_q <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/wp_keyseq.sv
module wp_keyseq
    import wp_keyseq_pkg::*;
#(
    parameter int GAP_LIMIT = 50000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              factory_init,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cycle_close,
    output logic              prot_on,
    output logic              autoclr_off,
    output logic              clear_pulse,
    output logic              commit_ok
);
    logic key_hit, busy, expire, live, unlock_q;
    cmd_e key_cmd;

    wp_keyseq_match u_match (
        .clk     (clk),
        .rst     (rst),
        .stb     (wr_stb),
        .adr     (wr_addr),
        .dat     (wr_data),
        .live    (live),
        .abort   (expire || cycle_close),
        .key_hit (key_hit),
        .key_cmd (key_cmd),
        .busy    (busy)
    );

    wp_keyseq_gap #(.LIMIT(GAP_LIMIT)) u_gap (
        .clk    (clk),
        .rst    (rst),
        .armed  (busy),
        .kick   (wr_stb),
        .expire (expire)
    );

    wp_keyseq_mode u_mode (
        .clk          (clk),
        .rst          (rst),
        .factory_init (factory_init),
        .stb          (wr_stb),
        .key_hit      (key_hit),
        .key_cmd      (key_cmd),
        .cycle_close  (cycle_close),
        .prot_on      (prot_on),
        .autoclr_off  (autoclr_off),
        .clear_pulse  (clear_pulse),
        .commit_ok    (commit_ok),
        .live         (live),
        .unlock_q     (unlock_q)
    );
endmodule

// File: rtl/wp_keyseq_chk.sv
module wp_keyseq_chk (
    input logic clk,
    input logic rst,
    input logic factory_init,
    input logic wr_stb,
    input logic cycle_close,
    input logic prot_on,
    input logic autoclr_off,
    input logic clear_pulse,
    input logic commit_ok,
    input logic unlock_q
);
    AST_INPUTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(wr_stb && cycle_close)); // R8

    AST_LOCK_MOVES_AT_CLOSE: assert property (@(posedge clk) disable iff (rst)
        (prot_on != $past(prot_on)) |-> $past(cycle_close || factory_init)); // R1

    AST_RESET_KEEPS_LOCK: assert property (@(posedge clk) disable iff (factory_init)
        (rst && prot_on) |=> prot_on); // R9

    AST_CLEAR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        clear_pulse |=> !clear_pulse); // R4

    AST_COMMIT_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        commit_ok |-> $past(wr_stb)); // R6

    AST_LOCKED_NEEDS_KEY: assert property (@(posedge clk) disable iff (rst)
        (commit_ok && $past(prot_on)) |-> $past(unlock_q)); // R2

    AST_ACFLAG_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        (autoclr_off != $past(autoclr_off)) |-> $past(wr_stb || rst)); // R5
endmodule

bind wp_keyseq wp_keyseq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .factory_init (factory_init),
    .wr_stb       (wr_stb),
    .cycle_close  (cycle_close),
    .prot_on      (prot_on),
    .autoclr_off  (autoclr_off),
    .clear_pulse  (clear_pulse),
    .commit_ok    (commit_ok),
    .unlock_q     (unlock_q)
);

// File: tb/tb_wp_keyseq.sv
`timescale 1ns/1ps
module tb_wp_keyseq;
    localparam int L = 24;

    logic clk = 1'b0;
    logic rst = 1'b1, factory_init = 1'b1, wr_stb = 1'b0, cycle_close = 1'b0;
    logic [12:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic prot_on, autoclr_off, clear_pulse, commit_ok;

    int n_chk = 0, n_fail = 0;

    // model state
    int m_step = 0, m_idle = 0;
    bit m_live = 1, m_prot = 0, m_unlock = 0, m_plock = 0, m_punlock = 0, m_seen = 0, m_ac = 0;

    always #2 clk = ~clk;

    wp_keyseq #(.GAP_LIMIT(L)) dut (
        .clk(clk), .rst(rst), .factory_init(factory_init), .wr_stb(wr_stb),
        .wr_addr(wr_addr), .wr_data(wr_data), .cycle_close(cycle_close),
        .prot_on(prot_on), .autoclr_off(autoclr_off), .clear_pulse(clear_pulse),
        .commit_ok(commit_ok)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int got, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    // result: 0 mismatch, 1 advance, 2 lock, 3 unlock, 4 wipe, 5 acoff, 6 acon
    function automatic int key_next(input int st, input logic [12:0] a, input logic [7:0] d);
        bit hi = (a == 13'h1555), lo = (a == 13'h0AAA);
        case (st)
            0, 3: return (hi && d == 8'hAA) ? 1 : 0;
            1, 4: return (lo && d == 8'h55) ? 1 : 0;
            2: return !hi ? 0 : (d == 8'hA0) ? 2 : (d == 8'h80) ? 1 : 0;
            5: return !hi ? 0 : (d == 8'h20) ? 3 : (d == 8'h10) ? 4 :
                               (d == 8'h40) ? 5 : (d == 8'h50) ? 6 : 0;
            default: return 0;
        endcase
    endfunction

    task automatic wr(input logic [12:0] a, input logic [7:0] d, input string tag);
        int code;
        bit e_commit = 0, e_clr = 0;
        code = m_live ? key_next(m_step, a, d) : 0;
        if (code == 1) m_step++;
        else begin
            m_step = 0;
            case (code)
                2: begin m_unlock = 1; m_plock = 1; m_punlock = 0; m_live = 0; end
                3: begin m_unlock = 1; m_punlock = 1; m_plock = 0; m_live = 0; end
                4: e_clr = 1;
                5: m_ac = 1;
                6: m_ac = 0;
                default: begin
                    m_live = 0;
                    e_commit = !m_prot || m_unlock;
                    if (e_commit) m_seen = 1;
                end
            endcase
        end
        m_idle = 0;
        wr_addr = a; wr_data = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        chk(commit_ok == e_commit, tag, "commit_ok", commit_ok, e_commit);
        chk(clear_pulse == e_clr, tag, "clear_pulse", clear_pulse, e_clr);
        chk(autoclr_off == m_ac, tag, "autoclr_off", autoclr_off, m_ac);
        chk(prot_on == m_prot, tag, "prot_on", prot_on, m_prot);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (m_step != 0) begin
                m_idle++;
                if (m_idle == L) begin m_step = 0; m_idle = 0; end
            end
        end
        if (n > 0) chk(!commit_ok && !clear_pulse, tag, "idle quiet", commit_ok | clear_pulse, 0);
    endtask

    task automatic close(input string tag);
        cycle_close = 1'b1;
        @(negedge clk);
        cycle_close = 1'b0;
        if (m_seen && m_plock) m_prot = 1;
        else if (m_seen && m_punlock) m_prot = 0;
        m_live = 1; m_unlock = 0; m_plock = 0; m_punlock = 0; m_seen = 0; m_step = 0; m_idle = 0;
        chk(prot_on == m_prot, tag, "prot_on after close", prot_on, m_prot);
    endtask

    task automatic do_rst();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_live = 1; m_unlock = 0; m_plock = 0; m_punlock = 0; m_seen = 0; m_step = 0; m_idle = 0; m_ac = 0;
        chk(prot_on == m_prot, "R9", "prot_on kept over rst", prot_on, m_prot);
        chk(!autoclr_off && !commit_ok && !clear_pulse, "R9", "rst outputs", autoclr_off, 0);
    endtask

    task automatic lock_key(input string tag);
        wr(13'h1555, 8'hAA, tag); wr(13'h0AAA, 8'h55, tag); wr(13'h1555, 8'hA0, tag);
    endtask

    task automatic long_key(input logic [7:0] fin, input int gap, input string tag);
        wr(13'h1555, 8'hAA, tag); wr(13'h0AAA, 8'h55, tag); wr(13'h1555, 8'h80, tag);
        wr(13'h1555, 8'hAA, tag); wr(13'h0AAA, 8'h55, tag);
        idle(gap, tag);
        wr(13'h1555, fin, tag);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0; factory_init = 1'b0;
        chk(!prot_on && !autoclr_off && !commit_ok && !clear_pulse, "R9", "reset state",
            {prot_on, autoclr_off, commit_ok, clear_pulse}, 0);

        // R1: lock key without data has no effect; with data it locks
        lock_key("R6"); close("R1");
        lock_key("R1"); wr(13'h0012, 8'h3C, "R1"); close("R1");
        // R2: locked and no key -> rejected; with key -> accepted
        wr(13'h0040, 8'h11, "R2"); close("R2");
        lock_key("R2"); wr(13'h0041, 8'h22, "R2"); wr(13'h0042, 8'h23, "R2"); close("R2");
        // R10: key-shaped write after data is data
        lock_key("R10"); wr(13'h0001, 8'h01, "R10"); wr(13'h1555, 8'hAA, "R10"); close("R10");
        // R4: whole-array clear pulse
        long_key(8'h10, 0, "R4"); idle(1, "R4");
        // R5: autoclear flag off then on
        long_key(8'h40, 0, "R5"); long_key(8'h50, 0, "R5");
        // R7: gap boundary
        long_key(8'h40, L-1, "R7"); long_key(8'h50, 0, "R7");
        long_key(8'h40, L, "R7"); close("R7");
        // R8: close abandons partial key
        wr(13'h1555, 8'hAA, "R8"); wr(13'h0AAA, 8'h55, "R8"); close("R8");
        wr(13'h1555, 8'hA0, "R8"); wr(13'h0003, 8'h05, "R8"); close("R8");
        // R3: unlock key with data
        long_key(8'h20, 0, "R3"); wr(13'h0100, 8'h77, "R3"); close("R3");
        wr(13'h0101, 8'h78, "R3"); close("R3");
        // R6: mismatching step aborts and is data
        wr(13'h1555, 8'hAA, "R6"); wr(13'h0AAA, 8'h56, "R6"); close("R6");
        // R9: reset keeps lock, clears flag; init clears lock
        lock_key("R9"); wr(13'h0005, 8'h09, "R9"); close("R9");
        long_key(8'h40, 0, "R9");
        do_rst();
        factory_init = 1'b1; @(negedge clk); factory_init = 1'b0; m_prot = 0;
        chk(prot_on == 0, "R9", "factory_init clears lock", prot_on, 0);

        // constrained random mix
        void'($urandom(32'h5EED_0042));
        for (int it = 0; it < 400; it++) begin
            case ($urandom_range(0, 7))
                0: lock_key("R1");
                1: begin
                    logic [7:0] f;
                    case ($urandom_range(0, 4))
                        0: f = 8'h20; 1: f = 8'h10; 2: f = 8'h40; 3: f = 8'h50; default: f = 8'h33;
                    endcase
                    long_key(f, $urandom_range(0, 3), "R3");
                end
                2, 3: for (int k = 0; k < int'($urandom_range(1, 4)); k++)
                          wr(13'($urandom_range(0, 8191)), 8'($urandom_range(0, 255)), "R2");
                4: close("R8");
                5: begin
                    int s = $urandom_range(0, 2);
                    if (s > 0) wr(13'h1555, 8'hAA, "R6");
                    if (s > 1) wr(13'h0AAA, 8'h55, "R6");
                    wr(13'($urandom_range(0, 8191)), 8'hAA, "R6");
                end
                6: idle($urandom_range(0, L + 4), "R7");
                default: if ($urandom_range(0, 9) == 0) do_rst(); else idle(1, "R10");
            endcase
        end
        summary();
    end
endmodule